// File: doc/BRIEF.md
# Branch condition evaluator

This block decides, in the cycle a conditional jump sits in the instruction register, whether that jump is taken. It receives the 5-bit operation code and the 3-bit condition code (instruction bits 25 down to 23). It also receives the negative, zero and carry status produced by the arithmetic unit, together with an enable that says when that status is fresh. The three status bits are held in a small flag register. The decision is an eight-way selection among a constant true input and the held flags or their inverses.

The condition codes come in complementary pairs: flipping the most significant code bit inverts the test. The one exception is the pair made of "always" and "carry clear". The output is combinational from the held flags and the current instruction fields. A control sequencer can therefore use it in the same cycle it presents the instruction.

Top module: `branch_decide`

## Requirements
- R1: `take_o` is 0 whenever `op_i` differs from the jump operation code 5'b01111, for every condition code and flag value.
- R2: With the jump operation code and condition 3'b000, `take_o` is 1 regardless of the flags.
- R3: Condition 3'b001 takes the jump when the held negative flag is 1. Condition 3'b010 takes it when the held zero flag is 1.
- R4: Condition 3'b011 (result not positive) takes the jump when the held negative flag or the held zero flag is 1.
- R5: Condition 3'b100 takes the jump when the held carry flag is 0.
- R6: Conditions 3'b101, 3'b110 and 3'b111 are the complements of 3'b001, 3'b010 and 3'b011. They take the jump on not negative, not zero, and positive (neither negative nor zero).
- R7: The held flags load `alu_n_i`, `alu_z_i` and `alu_c_i` on a rising clock edge only when `flag_we_i` is 1. When it is 0 they keep their value.
- R8: While `rst_n` is low the held flags are 0, even with `flag_we_i` high. Right after reset, conditions 000, 100, 101, 110 and 111 are taken and 001, 010 and 011 are not.
- R9: `take_o` reflects a change of `op_i` or `cond_i` in the same cycle, with no register on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code field of the current instruction |
| cond_i | input | 3 | Condition code field (instruction bits 25..23) |
| alu_n_i | input | 1 | Negative status from the arithmetic unit |
| alu_z_i | input | 1 | Zero status from the arithmetic unit |
| alu_c_i | input | 1 | Carry-out status from the arithmetic unit |
| flag_we_i | input | 1 | Load enable for the held flags |
| take_o | output | 1 | 1 when the jump is taken |

## Verification
All eight condition codes are swept under several held flag patterns: all clear, negative only, zero only, carry only, and negative with carry. Each pattern separates a code from its complementary partner and from its neighbours. The zero-only pattern, for example, is the only one that tells "not positive" apart from "negative". Sweeps with a non-jump operation code show the forced-low output. Flag loads with the enable low, and during reset, show that the held state ignores the arithmetic unit's status at those times.

// File: rtl/bcond_pkg.sv
package bcond_pkg;
  localparam int unsigned COND_W = 3;
  localparam int unsigned N_COND = 1 << COND_W;
  localparam int unsigned HALF   = N_COND / 2;

  typedef enum logic [COND_W-1:0] {
    BC_ALWAYS = 3'b000,
    BC_NEG    = 3'b001,
    BC_ZERO   = 3'b010,
    BC_NPOS   = 3'b011,
    BC_NCARRY = 3'b100,
    BC_NNEG   = 3'b101,
    BC_NZERO  = 3'b110,
    BC_POS    = 3'b111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/bcond_flag_reg.sv
module bcond_flag_reg
  import bcond_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we_i,
  input  flags_t flags_i,
  output flags_t flags_o
);
  flags_t flags_d;
  flags_t flags_q;

  always_comb begin
    flags_d = flags_q;
    if (we_i) flags_d = flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R7
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (flags_q == $past(flags_i)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(flags_q));
endmodule

// File: rtl/bcond_select.sv
module bcond_select
  import bcond_pkg::*;
(
  input  flags_t            flags_i,
  input  logic [COND_W-1:0] cond_i,
  output logic              hit_o
);
  logic [HALF-1:0]   base;
  logic [N_COND-1:0] cand;

  // lower half: true, negative, zero, not positive
  always_comb begin
    base    = '0;
    base[0] = 1'b1;
    base[1] = flags_i.n;
    base[2] = flags_i.z;
    base[3] = flags_i.n | flags_i.z;
  end

  // upper half mirrors the lower half inverted, except slot HALF (carry clear)
  for (genvar i = 0; i < HALF; i++) begin : g_pair
    assign cand[i] = base[i];
    if (i == 0) begin : g_carry
      assign cand[i+HALF] = ~flags_i.c;
    end else begin : g_inv
      assign cand[i+HALF] = ~base[i];
    end
  end

  assign hit_o = cand[cond_i];
endmodule

// File: rtl/branch_decide.sv
module branch_decide
  import bcond_pkg::*;
#(
  parameter int unsigned    OP_W      = 5,
  parameter logic [OP_W-1:0] BR_OPCODE = 5'b01111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              alu_n_i,
  input  logic              alu_z_i,
  input  logic              alu_c_i,
  input  logic              flag_we_i,
  output logic              take_o
);
  flags_t alu_flags;
  flags_t held;
  logic   is_jump;
  logic   hit;

  assign alu_flags = '{n: alu_n_i, z: alu_z_i, c: alu_c_i};

  bcond_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (flag_we_i),
    .flags_i (alu_flags),
    .flags_o (held)
  );

  bcond_select u_sel (
    .flags_i (held),
    .cond_i  (cond_i),
    .hit_o   (hit)
  );

  assign is_jump = (op_i == BR_OPCODE);
  assign take_o  = is_jump & hit;

  // R1
  non_jump_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i != BR_OPCODE) |-> !take_o);

  // R2
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == BR_OPCODE) && (cond_i == BC_ALWAYS)) |-> take_o);

  // R5
  carry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == BR_OPCODE) && (cond_i == BC_NCARRY)) |-> (take_o == !held.c));

  // R6
  positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == BR_OPCODE) && (cond_i == BC_POS)) |-> (take_o == !(held.n | held.z)));
endmodule

// File: tb/branch_decide_tb_top.sv
module branch_decide_tb_top;
  logic       clk;
  logic       rst_n;
  logic [4:0] op;
  logic [2:0] cond;
  logic       an, az, ac, we;
  logic       take;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;
  item_t q[$];

  // flag model kept by the bench
  logic m_n, m_z, m_c;

  branch_decide dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .cond_i(cond),
    .alu_n_i(an), .alu_z_i(az), .alu_c_i(ac), .flag_we_i(we),
    .take_o(take)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic model(input logic [4:0] o, input logic [2:0] c,
                                 input logic n, input logic z, input logic cy);
    logic r;
    case (c)
      3'b000: r = 1'b1;
      3'b001: r = n;
      3'b010: r = z;
      3'b011: r = n | z;
      3'b100: r = ~cy;
      3'b101: r = ~n;
      3'b110: r = ~z;
      default: r = ~n & ~z;
    endcase
    return (o == 5'b01111) ? r : 1'b0;
  endfunction

  // driver: apply fields after a falling edge, queue the expected result
  task automatic drive(input logic [4:0] o, input logic [2:0] c, input string tag);
    item_t it;
    @(negedge clk);
    op   = o;
    cond = c;
    it.exp = model(o, c, m_n, m_z, m_c);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sweep(input logic [4:0] o, input string tag);
    for (int k = 0; k < 8; k++) drive(o, 3'(k), tag);
  endtask

  task automatic load_flags(input logic n, input logic z, input logic c, input logic en);
    @(negedge clk);
    op = 5'b00000; an = n; az = z; ac = c; we = en;
    @(negedge clk);
    we = 1'b0;
    if (en) begin m_n = n; m_z = z; m_c = c; end
  endtask

  // monitor: sample a quarter period after the driver
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (take !== it.exp) begin
          errors++;
          $display("FAIL %s op=%b cond=%b take=%b expected=%b", it.tag, op, cond, take, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op = '0; cond = '0; an = 1'b1; az = 1'b1; ac = 1'b1; we = 1'b1;
    m_n = 1'b0; m_z = 1'b0; m_c = 1'b0;
    repeat (4) @(negedge clk);
    we = 1'b0;
    rst_n = 1'b1;

    // R8: flags zero after reset despite enable high during reset
    sweep(5'b01111, "R8_reset");
    // R1: non-jump opcodes forced low
    sweep(5'b01110, "R1");
    sweep(5'b11111, "R1");

    // R3 R4 R6: negative only
    load_flags(1'b1, 1'b0, 1'b0, 1'b1);
    sweep(5'b01111, "R3_R4_R6_neg");
    // R3 R4 R6: zero only separates not-positive from negative
    load_flags(1'b0, 1'b1, 1'b0, 1'b1);
    sweep(5'b01111, "R3_R4_R6_zero");
    // R5 R2: carry only
    load_flags(1'b0, 1'b0, 1'b1, 1'b1);
    sweep(5'b01111, "R5_R2_carry");
    sweep(5'b01000, "R1");

    // R7: enable low leaves held flags unchanged
    load_flags(1'b1, 1'b1, 1'b0, 1'b0);
    sweep(5'b01111, "R7_hold");
    // R7: load negative with carry
    load_flags(1'b1, 1'b0, 1'b1, 1'b1);
    sweep(5'b01111, "R7_load");

    // R9: fields change every cycle, result follows at once
    drive(5'b01111, 3'b101, "R9");
    drive(5'b01111, 3'b001, "R9");
    drive(5'b00111, 3'b001, "R9");
    drive(5'b01111, 3'b000, "R9");

    @(negedge clk);
    @(negedge clk);
    #10;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule